// File: doc/BRIEF.md
# Multichannel Sliding-Window Sum Engine

This block keeps a set of running sums for each of several independent sample channels. Every window of every channel has its own length. When a sample tick arrives, the engine stores the new sample of each channel into one shared circular history memory. For each window it then fetches the sample that has just fallen out of that window and adds the difference between the new sample and the departing one to that window's accumulator. It makes one memory access per clock. No tapped delay line is kept per window, so the cost is one history word per channel position plus one accumulator per window.

A fixed sequencer visits the channels in ascending order. For each channel it writes the new sample first and then reads once per window. It then raises a one-cycle completion pulse when every sum for the tick is valid. A strobe that arrives while the sequencer is working is discarded and reported with a pulse. A compile-time option places an averaging stage in front of the engine. That stage folds a power-of-two group of consecutive samples into one stored value, which shrinks the history needed for long windows by the same factor.

Top module: `mss_moving_sum`

## Requirements
- R1: After reset every sum reads zero, and `busy_o`, `done_o` and `drop_o` are low.
- R2: After each completed tick, the sum for channel c and window w equals the total of the last N_w samples accepted on channel c, where N_w is field w (16 bits, window 0 in the least significant field) of `WIN_LENS`.
- R3: `done_o` is high for exactly one cycle. It rises NUM_CH*(NUM_WIN+1)+1 clock edges after the edge that accepted the strobe, and `busy_o` falls at that same edge.
- R4: A `valid_i` strobe seen while `busy_o` is high changes no sum and starts no tick, and `drop_o` is high in the following cycle. `drop_o` never rises after an idle cycle.
- R5: While fewer than N_w samples have been accepted since reset, window w holds the total of all samples accepted so far, because departing samples count as zero.
- R6: A sample on one channel has no effect on the sums of any other channel.
- R7: Sums stay correct after the history pointer has wrapped past DEPTH positions.
- R8: With DECIM_LOG2 = D > 0, only every 2^D-th accepted strobe runs a tick. The value stored and summed is floor(group total / 2^D). The other strobes give no `done_o` and leave the sums unchanged.
- R9: A window filled with N_w full-scale samples reads exactly N_w*(2^SAMPLE_W-1), with no wrap-around.
- R10: `busy_o` is high in the cycle after the accepting edge and stays high until the completion edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | New-sample strobe, one cycle |
| samples_i | input | NUM_CH*SAMPLE_W | One unsigned sample per channel, channel 0 in the low bits |
| busy_o | output | 1 | A tick is in progress |
| drop_o | output | 1 | A strobe was discarded in the previous cycle |
| done_o | output | 1 | One-cycle pulse: all sums for the tick are valid |
| sums_o | output | NUM_CH*NUM_WIN*ACC_W | Sum of channel c, window w at field c*NUM_WIN+w |

## Verification
The case that is hardest to reach is a window whose departing sample comes from a history slot that has already been reused after the pointer wrapped. A wrong modulo or a wrong order of write and read only shows up there. The stimulus runs well beyond DEPTH ticks with a pattern table that changes with the tick number, so each departing value differs from the value now stored in its neighbour slots. A strobe injected partway through a busy tick checks that discarded samples never reach the history. A second instance with the averaging stage is driven with strobe counts that do not divide evenly, so that partial groups stay invisible.

// File: rtl/mss_pkg.sv
package mss_pkg;

   localparam int unsigned LEN_W     = 16;
   localparam int unsigned LEN_MAX   = 32;
   localparam int unsigned LENS_BITS = LEN_W * LEN_MAX;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_RUN   = 2'd1,
      SQ_DRAIN = 2'd2
   } mss_state_e;

   // largest window length among the first n packed fields
   function automatic int unsigned mss_max_len(input logic [LENS_BITS-1:0] lens,
                                               input int unsigned n);
      int unsigned m;
      m = 0;
      for (int unsigned i = 0; i < LEN_MAX; i++) begin
         if (i < n && 32'(lens[i*LEN_W +: LEN_W]) > m)
            m = 32'(lens[i*LEN_W +: LEN_W]);
      end
      return m;
   endfunction

endpackage

// File: rtl/mss_history_ram.sv
module mss_history_ram #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned WORDS  = 256
) (
   input  logic              clk_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o
);

   logic [DATA_W-1:0] mem_q [WORDS];
   logic [DATA_W-1:0] rdata_q;

   // single port: one access per clock, read data one cycle later
   always_ff @(posedge clk_i) begin
      if (we_i) mem_q[addr_i] <= wdata_i;
      else      rdata_q       <= mem_q[addr_i];
   end

   assign rdata_o = rdata_q;

endmodule

// File: rtl/mss_preavg.sv
module mss_preavg #(
   parameter int unsigned NUM_CH     = 4,
   parameter int unsigned SAMPLE_W   = 8,
   parameter int unsigned DECIM_LOG2 = 3
) (
   input  logic                         clk_i,
   input  logic                         rst_i,
   input  logic                         in_valid_i,
   input  logic [NUM_CH*SAMPLE_W-1:0]   in_samples_i,
   output logic                         out_valid_o,
   output logic [NUM_CH*SAMPLE_W-1:0]   out_samples_o
);

   localparam int unsigned SUM_W = SAMPLE_W + DECIM_LOG2;

   logic [DECIM_LOG2-1:0] grp_cnt_q;
   logic                  grp_last;

   assign grp_last    = &grp_cnt_q;
   assign out_valid_o = in_valid_i & grp_last;

   always_ff @(posedge clk_i) begin
      if (rst_i)           grp_cnt_q <= '0;
      else if (in_valid_i) grp_cnt_q <= grp_cnt_q + 1'b1;
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [SUM_W-1:0] part_q;
      logic [SUM_W-1:0] total;

      assign total = part_q + SUM_W'(in_samples_i[c*SAMPLE_W +: SAMPLE_W]);
      assign out_samples_o[c*SAMPLE_W +: SAMPLE_W] = total[SUM_W-1:DECIM_LOG2];

      always_ff @(posedge clk_i) begin
         if (rst_i)           part_q <= '0;
         else if (in_valid_i) part_q <= grp_last ? '0 : total;
      end
   end

endmodule

// File: rtl/mss_sequencer.sv
module mss_sequencer
   import mss_pkg::*;
#(
   parameter int unsigned NUM_CH  = 4,
   parameter int unsigned NUM_WIN = 3,
   parameter int unsigned CH_W    = 2,
   parameter int unsigned WIN_W   = 2
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             start_i,
   output logic             busy_o,
   output logic             done_o,
   output logic             op_valid_o,
   output logic             op_write_o,
   output logic [CH_W-1:0]  op_ch_o,
   output logic [WIN_W-1:0] op_win_o,
   output logic             acc_en_o,
   output logic [CH_W-1:0]  acc_ch_o,
   output logic [WIN_W-1:0] acc_win_o
);

   localparam int unsigned SLOT_W = $clog2(NUM_WIN + 1);

   mss_state_e        state_q;
   logic [CH_W-1:0]   ch_q;
   logic [SLOT_W-1:0] slot_q;
   logic              done_q;
   logic              acc_en_q;
   logic [CH_W-1:0]   acc_ch_q;
   logic [WIN_W-1:0]  acc_win_q;
   logic              last_slot;
   logic              last_ch;
   logic [SLOT_W-1:0] slot_m1;

   assign last_slot = (slot_q == SLOT_W'(NUM_WIN));
   assign last_ch   = (ch_q == CH_W'(NUM_CH - 1));
   assign slot_m1   = slot_q - SLOT_W'(1);

   // slot 0 writes the new sample, slot k>0 reads the sample leaving window k-1
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q   <= SQ_IDLE;
         ch_q      <= '0;
         slot_q    <= '0;
         done_q    <= 1'b0;
         acc_en_q  <= 1'b0;
         acc_ch_q  <= '0;
         acc_win_q <= '0;
      end else begin
         done_q   <= 1'b0;
         acc_en_q <= 1'b0;
         case (state_q)
            SQ_IDLE: begin
               if (start_i) begin
                  state_q <= SQ_RUN;
                  ch_q    <= '0;
                  slot_q  <= '0;
               end
            end
            SQ_RUN: begin
               acc_en_q  <= (slot_q != '0);
               acc_ch_q  <= ch_q;
               acc_win_q <= WIN_W'(slot_m1);
               if (last_slot) begin
                  slot_q <= '0;
                  if (last_ch) state_q <= SQ_DRAIN;
                  else         ch_q    <= ch_q + 1'b1;
               end else begin
                  slot_q <= slot_q + 1'b1;
               end
            end
            SQ_DRAIN: begin
               state_q <= SQ_IDLE;
               done_q  <= 1'b1;
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign busy_o     = (state_q != SQ_IDLE);
   assign done_o     = done_q;
   assign op_valid_o = (state_q == SQ_RUN);
   assign op_write_o = (slot_q == '0);
   assign op_ch_o    = ch_q;
   assign op_win_o   = WIN_W'(slot_m1);
   assign acc_en_o   = acc_en_q;
   assign acc_ch_o   = acc_ch_q;
   assign acc_win_o  = acc_win_q;

endmodule

// File: rtl/mss_moving_sum.sv
module mss_moving_sum
   import mss_pkg::*;
#(
   parameter int unsigned NUM_CH     = 4,
   parameter int unsigned NUM_WIN    = 3,
   parameter int unsigned SAMPLE_W   = 8,
   parameter int unsigned DEPTH      = 64,
   parameter int unsigned DECIM_LOG2 = 0,
   parameter logic [NUM_WIN*LEN_W-1:0] WIN_LENS = {16'd48, 16'd16, 16'd4},
   localparam int unsigned MAX_WIN   = mss_max_len(LENS_BITS'(WIN_LENS), NUM_WIN),
   localparam int unsigned ACC_W     = SAMPLE_W + $clog2(MAX_WIN),
   localparam int unsigned SUMS_W    = NUM_CH * NUM_WIN * ACC_W
) (
   input  logic                       clk_i,
   input  logic                       rst_i,
   input  logic                       valid_i,
   input  logic [NUM_CH*SAMPLE_W-1:0] samples_i,
   output logic                       busy_o,
   output logic                       drop_o,
   output logic                       done_o,
   output logic [SUMS_W-1:0]          sums_o
);

   localparam int unsigned PTR_W  = $clog2(DEPTH);
   localparam int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
   localparam int unsigned WIN_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
   localparam int unsigned ADDR_W = CH_W + PTR_W;
   localparam int unsigned WORDS  = NUM_CH * DEPTH;
   localparam int unsigned FILL_W = $clog2(MAX_WIN + 1);

   // ---------------- elaboration checks ----------------
   if (DEPTH < 2 || DEPTH != (1 << PTR_W)) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (MAX_WIN >= DEPTH) begin : g_bad_win
      $error("every window must be shorter than DEPTH");
   end
   if (NUM_WIN < 1 || NUM_WIN > LEN_MAX) begin : g_bad_count
      $error("NUM_WIN out of range");
   end
   if (NUM_CH < 1 || SAMPLE_W < 1) begin : g_bad_shape
      $error("NUM_CH and SAMPLE_W must be nonzero");
   end
   if (DECIM_LOG2 > 8) begin : g_bad_decim
      $error("DECIM_LOG2 too large");
   end

   // ---------------- window length table ----------------
   logic [LEN_W-1:0] len_arr [NUM_WIN];
   for (genvar w = 0; w < NUM_WIN; w++) begin : g_len
      if (WIN_LENS[w*LEN_W +: LEN_W] == '0) begin : g_zero
         $error("window length of zero");
      end
      assign len_arr[w] = WIN_LENS[w*LEN_W +: LEN_W];
   end

   // ---------------- sequencer ----------------
   logic             seq_busy;
   logic             seq_done;
   logic             op_valid;
   logic             op_write;
   logic [CH_W-1:0]  op_ch;
   logic [WIN_W-1:0] op_win;
   logic             acc_en;
   logic [CH_W-1:0]  acc_ch;
   logic [WIN_W-1:0] acc_win;
   logic             tick_go;
   logic [NUM_CH*SAMPLE_W-1:0] tick_samples;
   logic             accept;

   assign accept = valid_i & ~seq_busy;

   // ---------------- optional pre-averaging ----------------
   if (DECIM_LOG2 > 0) begin : g_avg
      mss_preavg #(
         .NUM_CH     (NUM_CH),
         .SAMPLE_W   (SAMPLE_W),
         .DECIM_LOG2 (DECIM_LOG2)
      ) u_preavg (
         .clk_i         (clk_i),
         .rst_i         (rst_i),
         .in_valid_i    (accept),
         .in_samples_i  (samples_i),
         .out_valid_o   (tick_go),
         .out_samples_o (tick_samples)
      );
   end else begin : g_direct
      assign tick_go      = accept;
      assign tick_samples = samples_i;
   end

   mss_sequencer #(
      .NUM_CH  (NUM_CH),
      .NUM_WIN (NUM_WIN),
      .CH_W    (CH_W),
      .WIN_W   (WIN_W)
   ) u_seq (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .start_i    (tick_go),
      .busy_o     (seq_busy),
      .done_o     (seq_done),
      .op_valid_o (op_valid),
      .op_write_o (op_write),
      .op_ch_o    (op_ch),
      .op_win_o   (op_win),
      .acc_en_o   (acc_en),
      .acc_ch_o   (acc_ch),
      .acc_win_o  (acc_win)
   );

   // ---------------- tick state ----------------
   logic [SAMPLE_W-1:0] samp_q [NUM_CH];
   logic [PTR_W-1:0]    head_q;
   logic [FILL_W-1:0]   fill_q;
   logic                drop_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         for (int c = 0; c < NUM_CH; c++) samp_q[c] <= '0;
      end else if (tick_go) begin
         for (int c = 0; c < NUM_CH; c++) samp_q[c] <= tick_samples[c*SAMPLE_W +: SAMPLE_W];
      end
   end

   // head and fill count advance once per finished tick
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         head_q <= '0;
         fill_q <= '0;
         drop_q <= 1'b0;
      end else begin
         drop_q <= valid_i & seq_busy;
         if (seq_done) begin
            head_q <= head_q + 1'b1;
            if (32'(fill_q) < MAX_WIN) fill_q <= fill_q + 1'b1;
         end
      end
   end

   // ---------------- history memory ----------------
   logic [LEN_W-1:0]    cur_len;
   logic [PTR_W-1:0]    rd_ptr;
   logic [ADDR_W-1:0]   mem_addr;
   logic [SAMPLE_W-1:0] mem_rdata;
   logic                live_q;

   assign cur_len  = (32'(op_win) < NUM_WIN) ? len_arr[op_win] : '0;
   assign rd_ptr   = head_q - PTR_W'(cur_len);
   assign mem_addr = op_write ? {op_ch, head_q} : {op_ch, rd_ptr};

   mss_history_ram #(
      .DATA_W (SAMPLE_W),
      .ADDR_W (ADDR_W),
      .WORDS  (WORDS)
   ) u_hist (
      .clk_i   (clk_i),
      .we_i    (op_valid & op_write),
      .addr_i  (mem_addr),
      .wdata_i (samp_q[op_ch]),
      .rdata_o (mem_rdata)
   );

   // a departing sample exists only once the window has been filled
   always_ff @(posedge clk_i) begin
      if (rst_i)                     live_q <= 1'b0;
      else if (op_valid & ~op_write) live_q <= (32'(fill_q) >= 32'(cur_len));
   end

   // ---------------- accumulators ----------------
   logic [ACC_W-1:0]    sums_q [NUM_CH][NUM_WIN];
   logic [SAMPLE_W-1:0] x_new;
   logic [SAMPLE_W-1:0] y_old;

   assign x_new = samp_q[acc_ch];
   assign y_old = live_q ? mem_rdata : '0;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         for (int c = 0; c < NUM_CH; c++)
            for (int w = 0; w < NUM_WIN; w++)
               sums_q[c][w] <= '0;
      end else if (acc_en) begin
         sums_q[acc_ch][acc_win] <= sums_q[acc_ch][acc_win]
                                    + ACC_W'(x_new) - ACC_W'(y_old);
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_out_ch
      for (genvar w = 0; w < NUM_WIN; w++) begin : g_out_win
         assign sums_o[(c*NUM_WIN + w)*ACC_W +: ACC_W] = sums_q[c][w];
      end
   end

   assign busy_o = seq_busy;
   assign done_o = seq_done;
   assign drop_o = drop_q;

endmodule

// File: rtl/mss_checker.sv
module mss_checker #(
   parameter int unsigned SUMS_W = 8
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic              valid_i,
   input logic              busy_o,
   input logic              drop_o,
   input logic              done_o,
   input logic              tick_go,
   input logic [SUMS_W-1:0] sums_o
);

   assert_reset_clear_R1: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(rst_i) |-> (sums_o == '0 && !done_o && !busy_o && !drop_o));

   assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      !busy_o |=> $stable(sums_o));

   assert_done_single_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      done_o |=> !done_o);

   assert_done_at_end_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(busy_o) |-> done_o);

   assert_drop_flag_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      (valid_i && busy_o) |=> drop_o);

   assert_no_idle_drop_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      !busy_o |=> !drop_o);

   assert_start_busy_R10: assert property (@(posedge clk_i) disable iff (rst_i)
      tick_go |=> busy_o);

endmodule

bind mss_moving_sum mss_checker #(.SUMS_W(SUMS_W)) u_chk (
   .clk_i   (clk_i),
   .rst_i   (rst_i),
   .valid_i (valid_i),
   .busy_o  (busy_o),
   .drop_o  (drop_o),
   .done_o  (done_o),
   .tick_go (tick_go),
   .sums_o  (sums_o)
);

// File: tb/mss_moving_sum_tb.sv
module mss_moving_sum_tb;

   // main instance: 4 channels, windows 4/16/48, depth 64
   localparam int C     = 4;
   localparam int W     = 3;
   localparam int DEP   = 64;
   localparam int ACC_W = 14;
   localparam int LAT   = C * (W + 1) + 1;
   // averaging instance: 2 channels, windows 2/6, depth 8, groups of 8
   localparam int C2    = 2;
   localparam int W2    = 2;
   localparam int ACC2  = 11;
   localparam int LAT2  = C2 * (W2 + 1) + 1;

   localparam logic [31:0] STIM [16] = '{
      32'h00000000, 32'h01020304, 32'hFF00FF00, 32'h10203040,
      32'h7F807F80, 32'h55AA55AA, 32'h0F0E0D0C, 32'hFFFFFFFF,
      32'h80000001, 32'h3C3C3C3C, 32'h12345678, 32'h9ABCDEF0,
      32'h00FF0000, 32'h01010101, 32'hC0FFEE00, 32'h7E7E0101
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #4 clk = ~clk;

   logic                 valid_a = 1'b0;
   logic [C*8-1:0]       samp_a  = '0;
   logic                 busy_a, drop_a, done_a;
   logic [C*W*ACC_W-1:0] sums_a;

   logic                   valid_b = 1'b0;
   logic [C2*8-1:0]        samp_b  = '0;
   logic                   busy_b, drop_b, done_b;
   logic [C2*W2*ACC2-1:0]  sums_b;

   mss_moving_sum #(
      .NUM_CH(C), .NUM_WIN(W), .SAMPLE_W(8), .DEPTH(DEP), .DECIM_LOG2(0),
      .WIN_LENS({16'd48, 16'd16, 16'd4})
   ) u_dut (
      .clk_i(clk), .rst_i(rst), .valid_i(valid_a), .samples_i(samp_a),
      .busy_o(busy_a), .drop_o(drop_a), .done_o(done_a), .sums_o(sums_a)
   );

   mss_moving_sum #(
      .NUM_CH(C2), .NUM_WIN(W2), .SAMPLE_W(8), .DEPTH(8), .DECIM_LOG2(3),
      .WIN_LENS({16'd6, 16'd2})
   ) u_dut_avg (
      .clk_i(clk), .rst_i(rst), .valid_i(valid_b), .samples_i(samp_b),
      .busy_o(busy_b), .drop_o(drop_b), .done_o(done_b), .sums_o(sums_b)
   );

   int total = 0;
   int bad   = 0;
   bit finished = 0;

   int hist [C][512];
   int ntick = 0;
   int hist2 [C2][64];
   int ntick2 = 0;
   int grp_sum [C2];
   int grp_n = 0;

   function automatic int len_a(int w);
      return (w == 0) ? 4 : (w == 1) ? 16 : 48;
   endfunction

   function automatic int len_b(int w);
      return (w == 0) ? 2 : 6;
   endfunction

   function automatic int model_a(int c, int w);
      int s = 0;
      for (int k = 0; k < len_a(w); k++)
         if (ntick - 1 - k >= 0) s += hist[c][ntick - 1 - k];
      return s;
   endfunction

   function automatic int model_b(int c, int w);
      int s = 0;
      for (int k = 0; k < len_b(w); k++)
         if (ntick2 - 1 - k >= 0) s += hist2[c][ntick2 - 1 - k];
      return s;
   endfunction

   function automatic int got_a(int c, int w);
      return int'(sums_a[(c*W + w)*ACC_W +: ACC_W]);
   endfunction

   function automatic int got_b(int c, int w);
      return int'(sums_b[(c*W2 + w)*ACC2 +: ACC2]);
   endfunction

   task automatic chk(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d (tick %0d)", req, act, exp, ntick);
      end
   endtask

   task automatic finish_up();
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      valid_a = 1'b0;
      valid_b = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      ntick = 0;
      ntick2 = 0;
      grp_n = 0;
      for (int c = 0; c < C2; c++) grp_sum[c] = 0;
   endtask

   // compare all main sums; the tag follows the regime of each window
   task automatic check_all_a();
      for (int c = 0; c < C; c++)
         for (int w = 0; w < W; w++) begin
            if (ntick <= len_a(w))  chk("R5", got_a(c, w), model_a(c, w));
            else if (ntick > DEP)   chk("R7", got_a(c, w), model_a(c, w));
            else                    chk("R2", got_a(c, w), model_a(c, w));
         end
   endtask

   // one tick on the main instance; junk_at > 0 injects a strobe while busy
   task automatic run_tick(logic [C*8-1:0] s, int junk_at);
      int  n = 0;
      bit  seen = 0;
      @(negedge clk);
      valid_a = 1'b1;
      samp_a  = s;
      for (int c = 0; c < C; c++) hist[c][ntick] = int'(s[c*8 +: 8]);
      ntick++;
      while (!seen && n < 60) begin
         @(negedge clk);
         n++;
         if (n == 1) begin
            valid_a = 1'b0;
            chk("R10", int'(busy_a), 1);
         end
         if (junk_at > 0 && n == junk_at) begin
            valid_a = 1'b1;
            samp_a  = ~s;
         end
         if (junk_at > 0 && n == junk_at + 1) begin
            valid_a = 1'b0;
            chk("R4", int'(drop_a), 1);
         end
         if (done_a) seen = 1;
      end
      chk("R3", n - 1, LAT);
      chk("R3", int'(busy_a), 0);
      @(negedge clk);
      chk("R3", int'(done_a), 0);
      check_all_a();
   endtask

   // one raw strobe on the averaging instance
   task automatic run_raw(logic [C2*8-1:0] s);
      int  n = 0;
      bit  seen = 0;
      bit  expect_tick;
      @(negedge clk);
      valid_b = 1'b1;
      samp_b  = s;
      for (int c = 0; c < C2; c++) grp_sum[c] += int'(s[c*8 +: 8]);
      grp_n++;
      expect_tick = (grp_n == 8);
      if (expect_tick) begin
         for (int c = 0; c < C2; c++) begin
            hist2[c][ntick2] = grp_sum[c] / 8;
            grp_sum[c] = 0;
         end
         ntick2++;
         grp_n = 0;
      end
      while (!seen && n < 14) begin
         @(negedge clk);
         n++;
         if (n == 1) valid_b = 1'b0;
         if (done_b) seen = 1;
      end
      if (expect_tick) chk("R8", n - 1, LAT2);
      else             chk("R8", int'(seen), 0);
      for (int c = 0; c < C2; c++)
         for (int w = 0; w < W2; w++)
            chk("R8", got_b(c, w), model_b(c, w));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      finish_up();
   end

   initial begin
      do_reset();
      @(negedge clk);
      // R1: reset state at the ports
      chk("R1", int'(busy_a), 0);
      chk("R1", int'(done_a), 0);
      chk("R1", int'(drop_a), 0);
      for (int c = 0; c < C; c++)
         for (int w = 0; w < W; w++) chk("R1", got_a(c, w), 0);

      // R2, R5, R7: table-driven stream, runs past the pointer wrap
      for (int t = 0; t < 90; t++) begin
         logic [C*8-1:0] v;
         v = STIM[t % 16] ^ {4{8'(t * 7)}};
         run_tick(v, 0);
      end

      // R4: strobe while busy is discarded
      run_tick(32'h11223344, 5);
      run_tick(32'h01010101, 0);
      repeat (20) @(negedge clk);
      chk("R4", int'(busy_a), 0);
      check_all_a();

      // R6: only channel 2 carries data after reset
      do_reset();
      run_tick(32'h005A0000, 0);
      for (int c = 0; c < C; c++)
         for (int w = 0; w < W; w++)
            chk("R6", got_a(c, w), (c == 2) ? 90 : 0);

      // R9: full-scale samples fill every window without wrap
      do_reset();
      for (int t = 0; t < 52; t++) run_tick(32'hFFFFFFFF, 0);
      for (int c = 0; c < C; c++)
         for (int w = 0; w < W; w++)
            chk("R9", got_a(c, w), len_a(w) * 255);

      // R8: averaging instance, uneven strobe count leaves a partial group
      do_reset();
      for (int k = 0; k < 85; k++) begin
         logic [C2*8-1:0] v;
         v = {8'(k * 29 + 3), 8'(255 - k * 11)};
         run_raw(v);
      end

      finish_up();
   end

endmodule